// File: doc/BRIEF.md
# Edge Detect Interrupt Controller

This block watches a vector of digital input channels, which are already filtered, and reports transitions on them to software. Each channel has two select bits, one for rising transitions and one for falling transitions. A control register gates the two directions globally, enables edge and overflow reporting, and enables the interrupt line. A transition that qualifies sets an edge-pending flag. If another qualifying transition arrives while that flag is still set, an overflow flag is raised as well. Software reads a status byte and acknowledges the flags by writing ones to a clear register.

Transitions are found by comparing each input with a copy of it that is one cycle old. A transition on the input vector therefore shows up in the status register one clock edge after the input changes. Registers are accessed one byte at a time. Writes are synchronous, and reads are combinational on the address.

Top module: `edge_irq_ctrl`

## Requirements
- R1: After reset, both select masks read 0, control reads 0, status reads 0 and `irq` is low.
- R2: Rising selects occupy bytes at addresses 0 (channels 7..0) and 1 (channels 15..8), and falling selects occupy addresses 2 and 3 in the same way. Each byte reads back what was last written to it, and a write to one byte leaves every other byte unchanged.
- R3: A 0-to-1 change on channel i sets status bit 0 at the next clock edge. This requires rising select bit i, control bit 3 (rising gate) and control bit 0 (edge enable) to all be 1.
- R4: A 1-to-0 change on channel i sets status bit 0 at the next clock edge. This requires falling select bit i, control bit 4 (falling gate) and control bit 0 to all be 1.
- R5: A change whose select bit, direction gate or control bit 0 is 0 leaves status bit 0 unchanged.
- R6: A qualifying change while status bit 0 is already 1 sets status bit 1 (overflow), provided control bit 1 is 1. When control bit 1 is 0, the overflow flag stays 0.
- R7: Writing to the clear register at address 6 acknowledges flags. A 1 in bit 3 clears the edge flag, and a 1 in bit 2 clears the overflow flag; setting both bits clears both. The clear register reads 0.
- R8: `irq` and status bit 2 both equal control bit 2 AND ((edge flag AND control bit 0) OR (overflow flag AND control bit 1)). Writing 0 to control therefore drops `irq`.
- R9: When a clear write and a qualifying change fall in the same cycle, setting wins. The edge flag stays 1, and if the edge flag was already 1 and control bit 1 is 1, the overflow flag is set.
- R10: Control is at address 4 and reads back bits 4..0 with the upper bits reading 0. Status is at address 5 and is read-only: writes to it change nothing. Any other address reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W (4) | Register byte address |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| ch_in | input | N_CH (16) | Filtered channel inputs |
| irq | output | 1 | Interrupt request, active high |

## Verification
Two functions can land in the same clock: software acknowledging a flag through the clear register, and a fresh qualifying transition. The bench forces the collision by driving a clear write of both flag bits in the same cycle that it changes a selected input, once with the edge flag already pending. It then expects the status to show the edge still pending, the overflow raised and the interrupt asserted, because setting takes priority over clearing. Around this, the bench sweeps every channel against both directions and all combinations of select bits, gates and edge enable, and it predicts each status byte arithmetically.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;

   // control register bit positions (software decodes these)
   localparam int CTL_EDGE_EN   = 0;
   localparam int CTL_OVF_EN    = 1;
   localparam int CTL_IRQ_EN    = 2;
   localparam int CTL_RISE_GATE = 3;
   localparam int CTL_FALL_GATE = 4;
   localparam int CTL_W         = 5;

   // status register bit positions
   localparam int ST_EDGE = 0;
   localparam int ST_OVF  = 1;
   localparam int ST_IRQ  = 2;

   // clear register bit positions
   localparam int CLR_OVF  = 2;
   localparam int CLR_EDGE = 3;

   typedef struct packed {
      logic fall_gate;
      logic rise_gate;
      logic irq_en;
      logic ovf_en;
      logic edge_en;
   } ctrl_t;

   typedef enum logic [2:0] {
      RK_RISE = 3'd0,
      RK_FALL = 3'd1,
      RK_CTRL = 3'd2,
      RK_STAT = 3'd3,
      RK_CLR  = 3'd4,
      RK_NONE = 3'd5
   } reg_kind_e;

   // classify a byte address given the number of select bytes per direction
   function automatic reg_kind_e classify(input int unsigned addr, input int unsigned nb);
      if (addr < nb)                 return RK_RISE;
      else if (addr < 2 * nb)        return RK_FALL;
      else if (addr == 2 * nb)       return RK_CTRL;
      else if (addr == 2 * nb + 1)   return RK_STAT;
      else if (addr == 2 * nb + 2)   return RK_CLR;
      else                           return RK_NONE;
   endfunction

endpackage

// File: rtl/edge_irq_detect.sv
module edge_irq_detect
   import edge_irq_pkg::*;
#(
   parameter int N_CH = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [N_CH-1:0] ch_in,
   input  logic [N_CH-1:0] rise_sel,
   input  logic [N_CH-1:0] fall_sel,
   input  ctrl_t           ctrl,
   output logic            hit
);

   logic [N_CH-1:0] ch_prev;
   logic [N_CH-1:0] chan_hit;

   for (genvar i = 0; i < N_CH; i++) begin : g_chan
      logic went_up;
      logic went_down;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) ch_prev[i] <= 1'b0;
         else        ch_prev[i] <= ch_in[i];
      end

      assign went_up     = ch_in[i] & ~ch_prev[i];
      assign went_down   = ~ch_in[i] & ch_prev[i];
      assign chan_hit[i] = (went_up   & rise_sel[i] & ctrl.rise_gate) |
                           (went_down & fall_sel[i] & ctrl.fall_gate);
   end

   assign hit = ctrl.edge_en & (|chan_hit);

endmodule

// File: rtl/edge_irq_regs.sv
module edge_irq_regs
   import edge_irq_pkg::*;
#(
   parameter int N_CH   = 16,
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   input  logic              edge_pend,
   input  logic              ovf_pend,
   input  logic              irq,
   output logic [N_CH-1:0]   rise_sel,
   output logic [N_CH-1:0]   fall_sel,
   output ctrl_t             ctrl,
   output logic              clr_edge_stb,
   output logic              clr_ovf_stb
);

   localparam int NB = N_CH / 8;

   logic [NB-1:0][7:0] rise_q;
   logic [NB-1:0][7:0] fall_q;
   ctrl_t              ctrl_q;
   reg_kind_e          kind;
   int unsigned        addr_u;

   assign addr_u = int'(bus_addr);
   assign kind   = classify(addr_u, NB);

   for (genvar b = 0; b < NB; b++) begin : g_byte
      logic wr_rise;
      logic wr_fall;

      assign wr_rise = bus_wr && (addr_u == b);
      assign wr_fall = bus_wr && (addr_u == NB + b);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rise_q[b] <= '0;
            fall_q[b] <= '0;
         end else begin
            if (wr_rise) rise_q[b] <= bus_wdata;
            if (wr_fall) fall_q[b] <= bus_wdata;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        ctrl_q <= '0;
      else if (bus_wr && kind == RK_CTRL) ctrl_q <= ctrl_t'(bus_wdata[CTL_W-1:0]);
   end

   assign clr_edge_stb = bus_wr && (kind == RK_CLR) && bus_wdata[CLR_EDGE];
   assign clr_ovf_stb  = bus_wr && (kind == RK_CLR) && bus_wdata[CLR_OVF];

   assign rise_sel = rise_q;
   assign fall_sel = fall_q;
   assign ctrl     = ctrl_q;

   always_comb begin
      bus_rdata = '0;
      unique case (kind)
         RK_RISE: begin
            for (int b = 0; b < NB; b++)
               if (addr_u == b) bus_rdata = rise_q[b];
         end
         RK_FALL: begin
            for (int b = 0; b < NB; b++)
               if (addr_u == NB + b) bus_rdata = fall_q[b];
         end
         RK_CTRL: bus_rdata[CTL_W-1:0] = ctrl_q;
         RK_STAT: begin
            bus_rdata[ST_EDGE] = edge_pend;
            bus_rdata[ST_OVF]  = ovf_pend;
            bus_rdata[ST_IRQ]  = irq;
         end
         default: bus_rdata = '0;
      endcase
   end

endmodule

// File: rtl/edge_irq_flags.sv
module edge_irq_flags
   import edge_irq_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  hit,
   input  ctrl_t ctrl,
   input  logic  clr_edge_stb,
   input  logic  clr_ovf_stb,
   output logic  edge_pend,
   output logic  ovf_pend,
   output logic  irq
);

   logic ovf_set;

   assign ovf_set = hit & edge_pend & ctrl.ovf_en;

   // setting takes priority over a same-cycle clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         edge_pend <= 1'b0;
         ovf_pend  <= 1'b0;
      end else begin
         if (hit)               edge_pend <= 1'b1;
         else if (clr_edge_stb) edge_pend <= 1'b0;
         if (ovf_set)           ovf_pend  <= 1'b1;
         else if (clr_ovf_stb)  ovf_pend  <= 1'b0;
      end
   end

   assign irq = ctrl.irq_en & ((edge_pend & ctrl.edge_en) | (ovf_pend & ctrl.ovf_en));

endmodule

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl
   import edge_irq_pkg::*;
#(
   parameter int N_CH   = 16,
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   input  logic [N_CH-1:0]   ch_in,
   output logic              irq
);

   localparam int NB      = N_CH / 8;
   localparam int N_REGS  = 2 * NB + 3;

   if (N_CH < 8 || (N_CH % 8) != 0) begin : g_bad_width
      $error("N_CH must be a positive multiple of 8");
   end
   if (N_REGS > (1 << ADDR_W)) begin : g_bad_addr
      $error("ADDR_W too small for the register map");
   end

   logic [N_CH-1:0] rise_sel;
   logic [N_CH-1:0] fall_sel;
   ctrl_t           ctrl_q;
   logic            qual_hit;
   logic            edge_pend;
   logic            ovf_pend;
   logic            clr_edge_stb;
   logic            clr_ovf_stb;

   edge_irq_regs #(.N_CH(N_CH), .ADDR_W(ADDR_W)) u_regs (
      .clk          (clk),
      .rst_n        (rst_n),
      .bus_addr     (bus_addr),
      .bus_wr       (bus_wr),
      .bus_wdata    (bus_wdata),
      .bus_rdata    (bus_rdata),
      .edge_pend    (edge_pend),
      .ovf_pend     (ovf_pend),
      .irq          (irq),
      .rise_sel     (rise_sel),
      .fall_sel     (fall_sel),
      .ctrl         (ctrl_q),
      .clr_edge_stb (clr_edge_stb),
      .clr_ovf_stb  (clr_ovf_stb)
   );

   edge_irq_detect #(.N_CH(N_CH)) u_detect (
      .clk      (clk),
      .rst_n    (rst_n),
      .ch_in    (ch_in),
      .rise_sel (rise_sel),
      .fall_sel (fall_sel),
      .ctrl     (ctrl_q),
      .hit      (qual_hit)
   );

   edge_irq_flags u_flags (
      .clk          (clk),
      .rst_n        (rst_n),
      .hit          (qual_hit),
      .ctrl         (ctrl_q),
      .clr_edge_stb (clr_edge_stb),
      .clr_ovf_stb  (clr_ovf_stb),
      .edge_pend    (edge_pend),
      .ovf_pend     (ovf_pend),
      .irq          (irq)
   );

endmodule

// File: rtl/edge_irq_chk.sv
module edge_irq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       hit,
   input logic       edge_pend,
   input logic       ovf_pend,
   input logic [4:0] ctrl,
   input logic       clr_edge,
   input logic       irq
);

   assert_edge_set_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> edge_pend);

   assert_edge_cause_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(edge_pend) |-> $past(hit));

   assert_ovf_cause_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf_pend) |-> $past(hit && edge_pend && ctrl[1]));

   assert_clear_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      (clr_edge && !hit) |=> !edge_pend);

   assert_irq_source_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (ctrl[2] && (edge_pend || ovf_pend)));

   assert_set_wins_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      (clr_edge && hit) |=> edge_pend);

endmodule

bind edge_irq_ctrl edge_irq_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .hit       (qual_hit),
   .edge_pend (edge_pend),
   .ovf_pend  (ovf_pend),
   .ctrl      (ctrl_q),
   .clr_edge  (clr_edge_stb),
   .irq       (irq)
);

// File: tb/edge_irq_ctrl_tb.sv
`timescale 1ns/1ps
module edge_irq_ctrl_tb;

   localparam int N_CH   = 16;
   localparam int ADDR_W = 4;
   localparam logic [ADDR_W-1:0] A_RISE0 = 0, A_RISE1 = 1, A_FALL0 = 2, A_FALL1 = 3,
                                 A_CTRL = 4, A_STAT = 5, A_CLR = 6, A_HOLE = 9;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic              bus_wr = 1'b0;
   logic [7:0]        bus_wdata = '0;
   logic [7:0]        bus_rdata;
   logic [N_CH-1:0]   ch_in = '0;
   logic              irq;

   int vectors = 0;
   int errors  = 0;

   always #2.5 clk = ~clk;

   edge_irq_ctrl #(.N_CH(N_CH), .ADDR_W(ADDR_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ch_in(ch_in), .irq(irq)
   );

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      vectors++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [ADDR_W-1:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a;
      #0.5 d = bus_rdata;
   endtask

   task automatic drive(input logic [N_CH-1:0] v);
      @(negedge clk);
      ch_in = v;
      @(negedge clk);
   endtask

   task automatic check_stat(input string tag, input logic [7:0] exp);
      logic [7:0] d;
      rd(A_STAT, d);
      check(tag, d, exp);
      check({tag, " irq pin"}, {7'd0, irq}, {7'd0, exp[2]});
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      logic [7:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      for (int a = 0; a < 7; a++) begin
         rd(ADDR_W'(a), d);
         check("R1 reset register", d, 8'h00);
      end
      check("R1 reset irq", {7'd0, irq}, 8'h00);

      // R2: byte-wise select registers
      for (int a = 0; a < 4; a++) begin
         wr(ADDR_W'(a), 8'hA0 + 8'(a * 17));
      end
      for (int a = 0; a < 4; a++) begin
         rd(ADDR_W'(a), d);
         check("R2 select readback", d, 8'hA0 + 8'(a * 17));
      end
      wr(A_FALL0, 8'h3C);
      for (int a = 0; a < 4; a++) begin
         rd(ADDR_W'(a), d);
         check("R2 single byte update", d, (a == 2) ? 8'h3C : 8'hA0 + 8'(a * 17));
      end

      // R10: control readback, status read-only, clear reads 0, hole reads 0
      wr(A_CTRL, 8'hFF);
      rd(A_CTRL, d);
      check("R10 ctrl upper bits", d, 8'h1F);
      wr(A_CTRL, 8'h00);
      wr(A_STAT, 8'hFF);
      rd(A_STAT, d);
      check("R10 status read-only", d, 8'h00);
      rd(A_CTRL, d);
      check("R10 status write no effect on ctrl", d, 8'h00);
      rd(A_CLR, d);
      check("R10 clear reads zero", d, 8'h00);
      rd(A_HOLE, d);
      check("R10 unmapped reads zero", d, 8'h00);

      // R3 R4 R5: sweep every channel, both directions, all select/gate/enable combos
      for (int ch = 0; ch < N_CH; ch++) begin
         for (int dir = 0; dir < 2; dir++) begin
            for (int combo = 0; combo < 32; combo++) begin
               logic sr, sf, gr, gf, en, exp_e;
               logic [N_CH-1:0] one, rmask, fmask;
               string tag;
               sr = combo[0]; sf = combo[1]; gr = combo[2]; gf = combo[3]; en = combo[4];
               one   = N_CH'(1) << ch;
               rmask = sr ? one : '0;
               fmask = sf ? one : '0;
               drive(dir == 0 ? '0 : one);
               wr(A_RISE0, rmask[7:0]);  wr(A_RISE1, rmask[15:8]);
               wr(A_FALL0, fmask[7:0]);  wr(A_FALL1, fmask[15:8]);
               wr(A_CTRL, {3'b000, gf, gr, 1'b1, 1'b1, en});
               wr(A_CLR, 8'h0C);
               drive(dir == 0 ? one : '0);
               exp_e = en & ((dir == 0) ? (sr & gr) : (sf & gf));
               if (!exp_e)        tag = "R5 unqualified change";
               else if (dir == 0) tag = "R3 rising edge";
               else               tag = "R4 falling edge";
               check_stat(tag, {5'd0, exp_e, 1'b0, exp_e});
            end
         end
      end

      // R6 R7 R8: overflow, clearing, interrupt gating
      drive('0);
      wr(A_RISE0, 8'h01); wr(A_RISE1, 8'h00); wr(A_FALL0, 8'h00); wr(A_FALL1, 8'h00);
      wr(A_CTRL, 8'h1F);
      wr(A_CLR, 8'h0C);
      drive(16'h0001);
      check_stat("R3 first edge", 8'h05);
      drive(16'h0000);
      check_stat("R5 unselected fall", 8'h05);
      drive(16'h0001);
      check_stat("R6 overflow set", 8'h07);
      wr(A_CLR, 8'h08);
      check_stat("R7 clear edge only", 8'h06);
      wr(A_CTRL, 8'h1D);
      check_stat("R8 overflow gated off", 8'h02);
      wr(A_CTRL, 8'h1F);
      wr(A_CLR, 8'hF3);
      check_stat("R7 clear with zero bits 3 and 2", 8'h06);
      wr(A_CLR, 8'h04);
      check_stat("R7 clear overflow", 8'h00);

      wr(A_CTRL, 8'h1D);
      drive(16'h0000);
      drive(16'h0001);
      drive(16'h0000);
      drive(16'h0001);
      check_stat("R6 overflow disabled", 8'h05);
      wr(A_CTRL, 8'h1B);
      check_stat("R8 irq enable off", 8'h01);
      wr(A_CTRL, 8'h1F);
      check_stat("R8 irq enable on", 8'h05);
      wr(A_CTRL, 8'h00);
      check_stat("R8 control zero", 8'h01);
      wr(A_CTRL, 8'h1F);
      wr(A_CLR, 8'h0C);
      check_stat("R7 clear both", 8'h00);

      // R9: clear write and qualifying edge in the same cycle
      drive(16'h0000);
      drive(16'h0001);
      check_stat("R9 setup pending edge", 8'h05);
      drive(16'h0000);
      @(negedge clk);
      ch_in = 16'h0001; bus_addr = A_CLR; bus_wdata = 8'h0C; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
      check_stat("R9 set wins over clear", 8'h07);
      wr(A_CLR, 8'h0C);
      check_stat("R9 later clear", 8'h00);

      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

endmodule